// File: doc/BRIEF.md
# PCI Host Bridge Address Router

This block sits on the CPU side of a PCI host bridge. It accepts one CPU request per clock: an address, a size code, a read/write flag and a one-bit I/O folding mode. It decides which PCI-side space the request targets: the I/O space, the folded sparse I/O window, the direct configuration window, the configuration index and data ports, PCI memory, or the interrupt-acknowledge cycle. It then works out the PCI-side address. The result is registered and appears one clock after the request strobe, together with an error flag for requests that match no window or are malformed.

Two more paths are purely combinational. The bus-master path takes an address issued by a PCI device and sends it either to PCI memory or to system RAM. The interrupt path routes a device's interrupt pin onto one of two host interrupt lines, using a slot-based rotation.

A two-state controller governs the response. `ST_IDLE` means no response is presented. `ST_RESP` means a decoded response is valid. Any request strobe moves the controller to `ST_RESP`, whichever state it is in (transitions IDLE→RESP and RESP→RESP). A cycle without a strobe returns it to `ST_IDLE` (transitions RESP→IDLE and IDLE→IDLE). The folding mode is captured on the same edge as the request.

Top module: `hb_addr_router`

## Requirements
- R1: While reset is asserted and right after it, `rsp_valid`, `rsp_err`, `rsp_target` and `rsp_addr` are all zero.
- R2: `rsp_valid` is high in exactly the cycle after each cycle in which `req_valid` is high. The response echoes that request's size code and write flag.
- R3: Size codes are 0 = 1 byte, 1 = 2 bytes and 2 = 4 bytes. With mode low, an address in 0x80000000..0x807FFFFF is reported with target code 1 (I/O). Its translated address is the low 16 bits of the offset from 0x80000000.
- R4: With mode high, an address in 0x80000000..0x807FFFFF is reported with target code 2 (sparse I/O). Its translated address is offset[22:12] placed at bits [15:5], with offset[4:0] at bits [4:0].
- R5: An address in 0x80C00000..0xBF7FFFFF is reported with target code 1. Its translated address is the full offset from 0x80000000.
- R6: An address in 0x80800000..0x80BFFFFF is reported with target code 3 (direct configuration), ahead of the I/O mapping. Let i be the lowest set bit position among offset bits 11..21, counted from 0, or 11 if none of those bits is set. The translated address is offset[10:0] with i placed at bits [14:11].
- R7: An I/O request (target 1 or 2) of size code 2 whose translated address is 0xCF8 is reported with target code 4 (configuration index). If the translated address is 0xCFC, it is reported with target code 5 (configuration data). Any other size at those addresses stays plain I/O.
- R8: An address in 0xC0000000..0xFEFFFFFF is reported with target code 6 (PCI memory). Its translated address is the offset from 0xC0000000.
- R9: A read of size code 0 at 0xBFFFFFF0 is reported with target code 7 (interrupt acknowledge) and address 0. A write, or any wider access, at that address is an error.
- R10: An address outside every window, or a size code of 3, sets `rsp_err`. Such a response has target code 0 and address 0.
- R11: A bus-master address below 0x80000000 goes to PCI memory unchanged (`bm_to_ram` low). A bus-master address at or above 0x80000000 goes to RAM (`bm_to_ram` high) at the address minus 0x80000000.
- R12: With `irq_req` high, exactly one bit of `irq_line_out` is set, at index (pin + (devfn >> 3)) mod 2. With `irq_req` low, no bit is set.
- R13: The folding mode is taken on the accepting edge. Changing it afterwards does not alter the response already registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | CPU request strobe |
| req_addr | input | 32 | CPU request address |
| req_size | input | 2 | Size code: 0 = 1 B, 1 = 2 B, 2 = 4 B |
| req_write | input | 1 | 1 = write, 0 = read |
| io_sparse_mode | input | 1 | Level select: 1 = sparse folded I/O window |
| rsp_valid | output | 1 | Decoded response valid |
| rsp_target | output | 3 | Target code 0..7 |
| rsp_addr | output | 32 | Translated PCI-side address |
| rsp_size | output | 2 | Echoed size code |
| rsp_write | output | 1 | Echoed write flag |
| rsp_err | output | 1 | Unmapped or malformed request |
| bm_addr | input | 32 | Bus-master address |
| bm_to_ram | output | 1 | 1 = bus-master access goes to system RAM |
| bm_xlat_addr | output | 32 | Translated bus-master address |
| irq_req | input | 1 | Device interrupt level |
| irq_devfn | input | 8 | Device/function number of the requester |
| irq_pin | input | 2 | Interrupt pin 0..3 |
| irq_line_out | output | 2 | Host interrupt lines |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, an 8 MB sparse window, an 11-bit configuration select field and two interrupt lines. With these values, every size code, both read and write, and both mode levels can be swept over each address point. The address points are walking-one offsets in every window, the window edges, the folded images of the configuration ports, and about fifteen hundred pseudo-random addresses. The interrupt swizzle is checked exhaustively over all 256 device/function numbers, all four pins and both request levels.

// File: rtl/hb_router_pkg.sv
package hb_router_pkg;

    typedef enum logic [2:0] {
        TGT_NONE       = 3'd0,
        TGT_IO         = 3'd1,
        TGT_IO_SPARSE  = 3'd2,
        TGT_CFG_DIRECT = 3'd3,
        TGT_CFG_INDEX  = 3'd4,
        TGT_CFG_DATA   = 3'd5,
        TGT_MEM        = 3'd6,
        TGT_INTACK     = 3'd7
    } hb_target_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } hb_state_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;
    localparam logic [1:0] SZ_BAD  = 2'd3;

    typedef struct packed {
        hb_target_e  target;
        logic [31:0] addr;
        logic        err;
    } hb_decode_t;

endpackage

// File: rtl/hb_cpu_decode.sv
module hb_cpu_decode
    import hb_router_pkg::*;
#(
    parameter int          ADDR_W       = 32,
    parameter logic [31:0] IO_BASE      = 32'h8000_0000,
    parameter logic [31:0] IO_SPAN      = 32'h3F80_0000,
    parameter logic [31:0] SPARSE_SPAN  = 32'h0080_0000,
    parameter logic [31:0] CFG_BASE     = 32'h8080_0000,
    parameter logic [31:0] CFG_SPAN     = 32'h0040_0000,
    parameter logic [31:0] MEM_BASE     = 32'hC000_0000,
    parameter logic [31:0] MEM_SPAN     = 32'h3F00_0000,
    parameter logic [31:0] INTACK_ADDR  = 32'hBFFF_FFF0,
    parameter int          CONTIG_BITS  = 16,
    parameter int          SPARSE_LOW   = 5,
    parameter int          SPARSE_PAGE  = 12,
    parameter int          CFG_SEL_LO   = 11,
    parameter int          CFG_SEL_N    = 11,
    parameter logic [31:0] CFG_IDX_PORT = 32'h0000_0CF8,
    parameter logic [31:0] CFG_DAT_PORT = 32'h0000_0CFC
) (
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [1:0]        cpu_size,
    input  logic              cpu_write,
    input  logic              sparse_mode,
    output hb_decode_t        dec
);

    localparam int SPARSE_MSB = $clog2(SPARSE_SPAN) - 1;
    localparam int CFG_OFF_W  = $clog2(CFG_SPAN);
    localparam int SEL_W      = $clog2(CFG_SEL_N + 1);

    logic [ADDR_W-1:0]    io_off;
    logic [ADDR_W-1:0]    cfg_diff;
    logic [ADDR_W-1:0]    mem_off;
    logic [CFG_OFF_W-1:0] cfg_off;
    logic                 in_io, in_sparse, in_cfg, in_mem;
    logic [SEL_W-1:0]     sel_idx;
    logic                 sel_found;
    logic [ADDR_W-1:0]    cfg_xlat;
    logic [ADDR_W-1:0]    sparse_xlat;
    logic [ADDR_W-1:0]    contig_xlat;
    logic [ADDR_W-1:0]    io_xlat;

    assign io_off   = cpu_addr - IO_BASE;
    assign cfg_diff = cpu_addr - CFG_BASE;
    assign mem_off  = cpu_addr - MEM_BASE;
    assign cfg_off  = cfg_diff[CFG_OFF_W-1:0];

    assign in_io     = (cpu_addr >= IO_BASE)  && (io_off < IO_SPAN);
    assign in_sparse = in_io && (io_off < SPARSE_SPAN);
    assign in_cfg    = (cpu_addr >= CFG_BASE) && (cfg_diff < CFG_SPAN);
    assign in_mem    = (cpu_addr >= MEM_BASE) && (mem_off < MEM_SPAN);

    // lowest set bit of the one-hot device select field
    always_comb begin
        sel_idx   = SEL_W'(CFG_SEL_N);
        sel_found = 1'b0;
        for (int k = 0; k < CFG_SEL_N; k++) begin
            if (!sel_found && cfg_off[CFG_SEL_LO + k]) begin
                sel_idx   = SEL_W'(k);
                sel_found = 1'b1;
            end
        end
    end

    assign cfg_xlat    = ADDR_W'({sel_idx, cfg_off[CFG_SEL_LO-1:0]});
    assign sparse_xlat = ADDR_W'({io_off[SPARSE_MSB:SPARSE_PAGE], io_off[SPARSE_LOW-1:0]});
    assign contig_xlat = ADDR_W'(io_off[CONTIG_BITS-1:0]);

    always_comb begin
        if (in_sparse) io_xlat = sparse_mode ? sparse_xlat : contig_xlat;
        else           io_xlat = io_off;
    end

    always_comb begin
        dec.target = TGT_NONE;
        dec.addr   = '0;
        dec.err    = 1'b1;
        if (cpu_size == SZ_BAD) begin
            dec.err = 1'b1;
        end else if (cpu_addr == INTACK_ADDR) begin
            if (!cpu_write && cpu_size == SZ_BYTE) begin
                dec.target = TGT_INTACK;
                dec.err    = 1'b0;
            end
        end else if (in_cfg) begin
            dec.target = TGT_CFG_DIRECT;
            dec.addr   = cfg_xlat;
            dec.err    = 1'b0;
        end else if (in_io) begin
            dec.target = (in_sparse && sparse_mode) ? TGT_IO_SPARSE : TGT_IO;
            dec.addr   = io_xlat;
            dec.err    = 1'b0;
            if (cpu_size == SZ_WORD && io_xlat == CFG_IDX_PORT)
                dec.target = TGT_CFG_INDEX;
            else if (cpu_size == SZ_WORD && io_xlat == CFG_DAT_PORT)
                dec.target = TGT_CFG_DATA;
        end else if (in_mem) begin
            dec.target = TGT_MEM;
            dec.addr   = mem_off;
            dec.err    = 1'b0;
        end
    end

    always_comb begin
        if (!$isunknown(dec)) begin
            AST_SPARSE_FITS: assert (dec.target != TGT_IO_SPARSE || dec.addr < (32'd1 << CONTIG_BITS)); // R4
        end
    end

endmodule

// File: rtl/hb_bm_map.sv
module hb_bm_map #(
    parameter int          ADDR_W   = 32,
    parameter logic [31:0] RAM_BASE = 32'h8000_0000
) (
    input  logic [ADDR_W-1:0] bm_addr,
    output logic              bm_to_ram,
    output logic [ADDR_W-1:0] bm_xlat_addr
);

    assign bm_to_ram    = (bm_addr >= RAM_BASE);
    assign bm_xlat_addr = bm_to_ram ? (bm_addr - RAM_BASE) : bm_addr;

    always_comb begin
        if (!$isunknown(bm_addr)) begin
            AST_BM_NOT_ABOVE: assert (bm_xlat_addr <= bm_addr); // R11
        end
    end

endmodule

// File: rtl/hb_irq_swizzle.sv
module hb_irq_swizzle #(
    parameter int NUM_LINES  = 2,
    parameter int PIN_W      = 2,
    parameter int DEVFN_W    = 8,
    parameter int SLOT_SHIFT = 3
) (
    input  logic               irq_req,
    input  logic [DEVFN_W-1:0] irq_devfn,
    input  logic [PIN_W-1:0]   irq_pin,
    output logic [NUM_LINES-1:0] irq_out
);

    localparam int SUM_W = DEVFN_W + 1;

    logic [SUM_W-1:0] rot_sum;
    logic [SUM_W-1:0] line_sel;

    assign rot_sum  = SUM_W'(irq_devfn >> SLOT_SHIFT) + SUM_W'(irq_pin);
    assign line_sel = rot_sum % SUM_W'(NUM_LINES);

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        assign irq_out[g] = irq_req && (line_sel == SUM_W'(g));
    end

    always_comb begin
        if (!$isunknown({irq_req, irq_devfn, irq_pin})) begin
            AST_IRQ_ONEHOT: assert ($onehot0(irq_out) && (irq_req == (irq_out != '0))); // R12
        end
    end

endmodule

// File: rtl/hb_addr_router.sv
module hb_addr_router
    import hb_router_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int NUM_LINES = 2,
    parameter int DEVFN_W   = 8,
    parameter int PIN_W     = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [1:0]           req_size,
    input  logic                 req_write,
    input  logic                 io_sparse_mode,
    output logic                 rsp_valid,
    output logic [2:0]           rsp_target,
    output logic [ADDR_W-1:0]    rsp_addr,
    output logic [1:0]           rsp_size,
    output logic                 rsp_write,
    output logic                 rsp_err,
    input  logic [ADDR_W-1:0]    bm_addr,
    output logic                 bm_to_ram,
    output logic [ADDR_W-1:0]    bm_xlat_addr,
    input  logic                 irq_req,
    input  logic [DEVFN_W-1:0]   irq_devfn,
    input  logic [PIN_W-1:0]     irq_pin,
    output logic [NUM_LINES-1:0] irq_line_out
);

    hb_state_e   state_q, state_d;
    hb_decode_t  dec;
    hb_target_e  tgt_q;
    logic [ADDR_W-1:0] addr_q;
    logic [1:0]  size_q;
    logic        write_q;
    logic        err_q;

    hb_cpu_decode #(.ADDR_W(ADDR_W)) u_decode (
        .cpu_addr    (req_addr),
        .cpu_size    (req_size),
        .cpu_write   (req_write),
        .sparse_mode (io_sparse_mode),
        .dec         (dec)
    );

    hb_bm_map #(.ADDR_W(ADDR_W)) u_bm (
        .bm_addr      (bm_addr),
        .bm_to_ram    (bm_to_ram),
        .bm_xlat_addr (bm_xlat_addr)
    );

    hb_irq_swizzle #(
        .NUM_LINES (NUM_LINES),
        .PIN_W     (PIN_W),
        .DEVFN_W   (DEVFN_W)
    ) u_irq (
        .irq_req   (irq_req),
        .irq_devfn (irq_devfn),
        .irq_pin   (irq_pin),
        .irq_out   (irq_line_out)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = req_valid ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // registered response fields; mode is sampled through the decode on this edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q   <= TGT_NONE;
            addr_q  <= '0;
            size_q  <= SZ_BYTE;
            write_q <= 1'b0;
            err_q   <= 1'b0;
        end else if (req_valid) begin
            tgt_q   <= dec.target;
            addr_q  <= dec.addr;
            size_q  <= req_size;
            write_q <= req_write;
            err_q   <= dec.err;
        end
    end

    assign rsp_valid  = (state_q == ST_RESP);
    assign rsp_target = tgt_q;
    assign rsp_addr   = addr_q;
    assign rsp_size   = size_q;
    assign rsp_write  = write_q;
    assign rsp_err    = err_q;

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n) req_valid |=> rsp_valid); // R2
    AST_NO_RSP_UNASKED: assert property (@(posedge clk) disable iff (!rst_n) !req_valid |=> !rsp_valid); // R2
    AST_SIZE_ECHO: assert property (@(posedge clk) disable iff (!rst_n) req_valid |=> rsp_size == $past(req_size)); // R2
    AST_INTACK_BYTE_READ: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && rsp_target == TGT_INTACK) |-> (!rsp_write && rsp_size == SZ_BYTE)); // R9
    AST_CFG_PORT_WORD: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && (rsp_target == TGT_CFG_INDEX || rsp_target == TGT_CFG_DATA)) |-> rsp_size == SZ_WORD); // R7
    AST_ERR_CLEAN: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && rsp_err) |-> (rsp_target == TGT_NONE && rsp_addr == '0)); // R10
    AST_BAD_SIZE_ERR: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_size == SZ_BAD) |=> rsp_err); // R10

endmodule

// File: tb/hb_addr_router_bench.sv
module hb_addr_router_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic        io_sparse_mode = 1'b0;
    logic        rsp_valid;
    logic [2:0]  rsp_target;
    logic [31:0] rsp_addr;
    logic [1:0]  rsp_size;
    logic        rsp_write;
    logic        rsp_err;
    logic [31:0] bm_addr = '0;
    logic        bm_to_ram;
    logic [31:0] bm_xlat_addr;
    logic        irq_req = 1'b0;
    logic [7:0]  irq_devfn = '0;
    logic [1:0]  irq_pin = '0;
    logic [1:0]  irq_line_out;

    int checks = 0;
    int errors = 0;
    bit summary_done = 0;

    always #4 clk = ~clk;

    hb_addr_router u_hb_addr_router (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_write(req_write), .io_sparse_mode(io_sparse_mode),
        .rsp_valid(rsp_valid), .rsp_target(rsp_target), .rsp_addr(rsp_addr),
        .rsp_size(rsp_size), .rsp_write(rsp_write), .rsp_err(rsp_err),
        .bm_addr(bm_addr), .bm_to_ram(bm_to_ram), .bm_xlat_addr(bm_xlat_addr),
        .irq_req(irq_req), .irq_devfn(irq_devfn), .irq_pin(irq_pin),
        .irq_line_out(irq_line_out)
    );

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // reference model written from the requirement text
    function automatic void model(input logic [31:0] a, input logic [1:0] sz, input logic wr,
                                  input logic md, output logic [2:0] t, output logic [31:0] x,
                                  output logic e, output string tag);
        logic [31:0] off;
        int dev;
        t = 3'd0; x = 32'd0; e = 1'b1; tag = "R10";
        if (sz == 2'd3) return;
        if (a == 32'hBFFF_FFF0) begin
            tag = "R9";
            if (!wr && sz == 2'd0) begin t = 3'd7; e = 1'b0; end
            return;
        end
        if (a >= 32'h8080_0000 && a < 32'h80C0_0000) begin
            off = a - 32'h8080_0000;
            dev = 11;
            for (int k = 10; k >= 0; k--) if (off[11 + k]) dev = k;
            x = (32'(dev) << 11) | (off & 32'h7FF);
            t = 3'd3; e = 1'b0; tag = "R6";
            return;
        end
        if (a >= 32'h8000_0000 && a < 32'hBF80_0000) begin
            off = a - 32'h8000_0000;
            if (off < 32'h0080_0000) begin
                if (md) begin x = (off & 32'h1F) | ((off & 32'h007F_F000) >> 7); t = 3'd2; tag = "R4"; end
                else    begin x = off & 32'hFFFF; t = 3'd1; tag = "R3"; end
            end else begin
                x = off; t = 3'd1; tag = "R5";
            end
            e = 1'b0;
            if (sz == 2'd2 && x == 32'hCF8) begin t = 3'd4; tag = "R7"; end
            if (sz == 2'd2 && x == 32'hCFC) begin t = 3'd5; tag = "R7"; end
            return;
        end
        if (a >= 32'hC000_0000 && a < 32'hFF00_0000) begin
            x = a - 32'hC000_0000; t = 3'd6; e = 1'b0; tag = "R8";
        end
    endfunction

    task automatic run_req(input logic [31:0] a, input logic [1:0] sz, input logic wr, input logic md);
        logic [2:0]  et;
        logic [31:0] ex;
        logic        ee;
        string       tag;
        model(a, sz, wr, md, et, ex, ee, tag);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_size = sz; req_write = wr; io_sparse_mode = md;
        @(negedge clk);
        req_valid = 1'b0;
        check("R2", "valid", 32'(rsp_valid), 32'd1);
        check(tag, "target", 32'(rsp_target), 32'(et));
        check(tag, "addr", rsp_addr, ex);
        check(tag, "err", 32'(rsp_err), 32'(ee));
        check("R2", "size/write", {28'd0, rsp_size, 1'b0, rsp_write}, {28'd0, sz, 1'b0, wr});
    endtask

    task automatic sweep_addr(input logic [31:0] a);
        for (int s = 0; s < 4; s++)
            for (int w = 0; w < 2; w++)
                for (int m = 0; m < 2; m++)
                    run_req(a, 2'(s), 1'(w), 1'(m));
    endtask

    initial begin
        logic [31:0] rng;
        logic [31:0] specials [16];
        specials = '{32'h8000_0CF8, 32'h8000_0CFC, 32'h8006_7018, 32'h8006_701C,
                     32'h8000_0000, 32'h807F_FFFF, 32'h8080_0000, 32'h80BF_FFFF,
                     32'hBF7F_FFFF, 32'hBF80_0000, 32'hBFFF_FFF0, 32'hBFFF_FFEF,
                     32'h7FFF_FFFF, 32'hC000_0000, 32'hFEFF_FFFF, 32'hFF00_0000};

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", "valid in reset", 32'(rsp_valid), 32'd0);
        check("R1", "err in reset", 32'(rsp_err), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "valid after reset", 32'(rsp_valid), 32'd0);
        check("R1", "target after reset", 32'(rsp_target), 32'd0);
        check("R1", "addr after reset", rsp_addr, 32'd0);

        foreach (specials[i]) sweep_addr(specials[i]);
        for (int b = 0; b < 30; b++) begin
            sweep_addr(32'h8000_0000 + (32'd1 << b));
            sweep_addr(32'hC000_0000 + (32'd1 << b) - 32'd1);
        end
        for (int b = 0; b < 22; b++) sweep_addr(32'h8080_0000 + (32'd1 << b) + 32'h2A5);

        rng = 32'h1234_5678;
        for (int n = 0; n < 1500; n++) begin
            rng ^= rng << 13; rng ^= rng >> 17; rng ^= rng << 5;
            if (n % 2 == 0) sweep_addr({2'b10, rng[29:0]});
            else            sweep_addr(rng);
        end

        // R13: mode change after the accepting edge
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h8006_7018; req_size = 2'd2; req_write = 1'b0; io_sparse_mode = 1'b1;
        @(posedge clk);
        #1 io_sparse_mode = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        check("R13", "target held", 32'(rsp_target), 32'd4);
        check("R13", "addr held", rsp_addr, 32'h0000_0CF8);
        @(negedge clk);
        check("R2", "no valid without request", 32'(rsp_valid), 32'd0);

        // R11: bus-master map
        for (int b = 0; b < 32; b++) begin
            for (int v = 0; v < 2; v++) begin
                @(negedge clk);
                bm_addr = (32'd1 << b) - 32'(v);
                #1;
                check("R11", "to_ram", 32'(bm_to_ram), 32'(bm_addr >= 32'h8000_0000));
                check("R11", "xlat", bm_xlat_addr, (bm_addr >= 32'h8000_0000) ? bm_addr - 32'h8000_0000 : bm_addr);
            end
        end
        rng = 32'hCAFE_0001;
        for (int n = 0; n < 500; n++) begin
            rng ^= rng << 13; rng ^= rng >> 17; rng ^= rng << 5;
            @(negedge clk);
            bm_addr = rng;
            #1;
            check("R11", "to_ram", 32'(bm_to_ram), 32'(rng[31]));
            check("R11", "xlat", bm_xlat_addr, rng[31] ? rng - 32'h8000_0000 : rng);
        end

        // R12: exhaustive swizzle
        for (int d = 0; d < 256; d++)
            for (int p = 0; p < 4; p++)
                for (int r = 0; r < 2; r++) begin
                    @(negedge clk);
                    irq_devfn = 8'(d); irq_pin = 2'(p); irq_req = 1'(r);
                    #1;
                    check("R12", "lines", 32'(irq_line_out),
                          (r == 1) ? (32'd1 << (((d >> 3) + p) % 2)) : 32'd0);
                end

        if (!summary_done) begin
            summary_done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
        end
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!summary_done) begin
            summary_done = 1;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
        end
        $finish;
    end

endmodule